// File: doc/BRIEF.md
# Three-wire serial host controller

This block is the host side of a half-duplex, three-wire register link: an active-low select, a serial clock and one shared data line. A requester hands it a read or a write. Each request carries a 6-bit register address and, for writes, an 8-bit value. The block turns the request into a 16-slot serial frame. The serial clock comes from the system clock through a programmable divider. For reads, the block turns the data line around and returns the byte it collects, marked by a one-cycle done pulse.

Requests arrive on a valid/ready handshake. The requester raises `req_valid` with `req_rd`, `req_addr` and `req_wdata`, and must hold all of them steady until a clock edge where `req_ready` is also high. That edge is the transfer. `req_ready` is high while the block is idle. It is also high for the single cycle that closes a write frame, so a waiting request can be taken without gaps. A write taken in that cycle follows under the same select. A read taken there waits until select has been raised for a full serial period. The data line is split at the pad into `sd_out`, `sd_oe` and `sd_in`.

The divider setting `div_n` gives a serial clock period of 2×(`div_n`+1) system clocks. It is meant to change only while the block is idle.

Top module: `tw_reg_host`

## Requirements
- R1: A frame is 16 serial clock rising edges, sent most significant first. Slot 0 carries the direction bit (0 = write, 1 = read). Slots 1 to 6 carry address bits 5 down to 0. Slot 7 is a gap. Slots 8 to 15 carry data bits 7 down to 0.
- R2: `ser_clk` is low whenever `sel_n` is high. Within a select window its period is exactly 2×(`div_n`+1) system clocks. `sd_out` never changes while `ser_clk` stays high.
- R3: In a write frame, `sd_oe` is 1 for all 16 slots, and `sd_out` is 0 during the gap slot.
- R4: In a read frame, `sd_oe` is 1 for slots 0 to 6 and 0 from slot 7 to the end of the frame.
- R5: In a read frame, `sd_in` is sampled on the rising edges of slots 8 to 15, first bit into bit 7. After the frame, `rd_done` is high for exactly one cycle, and `rd_data` holds the byte in that cycle.
- R6: `sel_n` rises only after the high phase of the 16th serial clock has ended. A frame is never cut short.
- R7: If a write is taken in the closing cycle of a write frame, its frame follows with `sel_n` held low.
- R8: After every read frame, `sel_n` goes high. Every deselect lasts at least 2×(`div_n`+1) system clocks.
- R9: `req_ready` is low during the deselect time and throughout a frame. The one exception is the closing cycle of a write frame, in which `ser_clk` is high.
- R10: Out of reset: `sel_n`=1, `ser_clk`=0, `sd_oe`=0, `req_ready`=1, `rd_done`=0.
- R11: A read taken in the closing cycle of a write frame is not chained. Select rises, stays high for exactly 2×(`div_n`+1) cycles, and the read then runs in a select window of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_n | input | 8 | Divider setting N; serial period is 2×(N+1) clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 6 | Register address |
| req_wdata | input | 8 | Write value (ignored for reads) |
| rd_data | output | 8 | Collected read byte, valid with rd_done |
| rd_done | output | 1 | One-cycle pulse when a read frame completes |
| sel_n | output | 1 | Active-low select |
| ser_clk | output | 1 | Serial clock, idles low |
| sd_out | output | 1 | Data line value driven by the host |
| sd_oe | output | 1 | Host drives the data line when 1 |
| sd_in | input | 1 | Data line value seen at the pad |

## Verification
The assertions rely on three assumptions about the inputs:
- `div_n` is constant from the moment a request is taken until the block is idle again.
- A requester that raises `req_valid` keeps it and the payload steady until it is taken.
- The remote side changes `sd_in` only after a falling serial clock edge.

The bench keeps within these assumptions. It changes `div_n` only after waiting for idle. It drives every request from one task, which holds the fields until it sees ready. Its slave model updates `sd_in` a half system clock after it detects a falling edge.

// File: rtl/tw_host_pkg.sv
package tw_host_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DESEL = 2'd2
  } tw_state_e;
endpackage

// File: rtl/tw_host_clkgen.sv
module tw_host_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_n);

  // restart from zero whenever the engine is idle so each half lasts N+1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tw_host_shift.sv
module tw_host_shift #(
  parameter int AW = 6,
  parameter int DW = 8,
  localparam int FL = AW + DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ld_rd,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  input  logic          launch,
  input  logic          sample,
  input  logic          sd_in,
  output logic          bit_out,
  output logic [DW-1:0] rx
);
  logic [FL-1:0] sh;

  assign bit_out = sh[FL-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (load) begin
      // direction, address, gap slot held low, data (zero for reads)
      sh <= {ld_rd, ld_addr, 1'b0, (ld_rd ? {DW{1'b0}} : ld_wdata)};
    end else if (launch) begin
      sh <= {sh[FL-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx <= '0;
    else if (sample) rx <= {rx[DW-2:0], sd_in};
  end
endmodule

// File: rtl/tw_reg_host.sv
module tw_reg_host
  import tw_host_pkg::*;
#(
  parameter int AW    = 6,
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_rd,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic [DW-1:0]    rd_data,
  output logic             rd_done,
  output logic             sel_n,
  output logic             ser_clk,
  output logic             sd_out,
  output logic             sd_oe,
  input  logic             sd_in
);
  localparam int FL   = AW + DW + 2;
  localparam int PH_W = $clog2(2 * FL);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(2 * FL - 1);
  localparam logic [PH_W-2:0] SLOT_GAP  = (PH_W-1)'(AW + 1);
  localparam logic [PH_W-2:0] SLOT_DAT0 = (PH_W-1)'(AW + 2);

  tw_state_e        state;
  logic [PH_W-1:0]  ph;
  logic [PH_W-2:0]  slot;
  logic             cur_rd;
  logic             pend;
  logic             tick;
  logic             frame_end;
  logic             accept;
  logic             launch;
  logic             sample;
  logic             bit_out;

  assign slot      = ph[PH_W-1:1];
  assign frame_end = (state == ST_RUN) && tick && (ph == PH_LAST);
  assign req_ready = (state == ST_IDLE) || (frame_end && !cur_rd);
  assign accept    = req_valid && req_ready;
  assign launch    = (state == ST_RUN) && tick && ph[0] && (ph != PH_LAST);
  assign sample    = (state == ST_RUN) && tick && !ph[0] && cur_rd && (slot >= SLOT_DAT0);

  tw_host_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state != ST_IDLE),
    .div_n (div_n),
    .tick  (tick)
  );

  tw_host_shift #(.AW(AW), .DW(DW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .ld_rd    (req_rd),
    .ld_addr  (req_addr),
    .ld_wdata (req_wdata),
    .launch   (launch),
    .sample   (sample),
    .sd_in    (sd_in),
    .bit_out  (bit_out),
    .rx       (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ph      <= '0;
      cur_rd  <= 1'b0;
      pend    <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_rd <= req_rd;
            ph     <= '0;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (frame_end) begin
            rd_done <= cur_rd;
            ph      <= '0;
            if (accept && !req_rd) begin
              cur_rd <= 1'b0;              // burst write under same select
            end else begin
              state <= ST_DESEL;
              pend  <= accept;             // a read taken here waits out the gap
              if (accept) cur_rd <= 1'b1;
            end
          end else if (tick) begin
            ph <= ph + 1'b1;
          end
        end
        ST_DESEL: begin
          if (tick) begin
            if (ph[0]) begin
              ph    <= '0;
              pend  <= 1'b0;
              state <= pend ? ST_RUN : ST_IDLE;
            end else begin
              ph <= ph + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sel_n   = (state != ST_RUN);
  assign ser_clk = (state == ST_RUN) && ph[0];
  assign sd_oe   = (state == ST_RUN) && (!cur_rd || (slot < SLOT_GAP));
  assign sd_out  = bit_out;

  // R2: clock idles low outside a select window
  p_idle_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> !ser_clk);
  // R2: outgoing bit holds across a high phase
  p_stable_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && ser_clk && $past(ser_clk)) |-> $stable(sd_out));
  // R3: gap slot of a driven frame is low
  p_gap_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sd_oe && slot == SLOT_GAP) |-> !sd_out);
  // R4: the line is released mid-frame only on reads
  p_oe_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && $fell(sd_oe)) |-> cur_rd);
  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
  // R6: select rises only after a completed high phase
  p_sel_after_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> $past(ser_clk));
  // R8: every read frame ends with deselection
  p_read_desel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cur_rd) |=> sel_n);
  // R9: ready never shows inside a low phase of an active frame
  p_ready_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !ser_clk) |-> !req_ready);
  // R9: ready stays low during deselect
  p_ready_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DESEL) |-> !req_ready);
endmodule

// File: tb/test_tw_reg_host.sv
module test_tw_reg_host;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_n = 8'd0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_rd = 1'b0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] rd_data;
  logic       rd_done;
  logic       sel_n, ser_clk, sd_out, sd_oe;
  logic       sd_in = 1'b0;

  always #4 clk = ~clk;

  tw_reg_host i_tw_reg_host (
    .clk(clk), .rst_n(rst_n), .div_n(div_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_done(rd_done),
    .sel_n(sel_n), .ser_clk(ser_clk), .sd_out(sd_out), .sd_oe(sd_oe),
    .sd_in(sd_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic [7:0]  smem [64];
  logic [15:0] fr, last_frame;
  logic [15:0] oe_rec;
  logic [7:0]  cur_byte;
  logic        cur_rd_s;
  logic        prev_sck, prev_sel, prev_sd, prev_done;
  int nbits, rise_gap, desel_cnt, last_desel, win_frames, last_win_frames;
  int frames_total, rdy_sel, n_done;
  int viol_r2, viol_r3, viol_r4, viol_r5, viol_r6, viol_r8;
  logic [7:0] last_rd;

  initial for (int i = 0; i < 64; i++) smem[i] = 8'(i * 7 + 3);

  always @(negedge clk) begin
    if (!rst_n) begin
      fr = '0; last_frame = '0; oe_rec = '0; cur_byte = '0; cur_rd_s = 0;
      prev_sck = 0; prev_sel = 1; prev_sd = 0; prev_done = 0;
      nbits = 0; rise_gap = 0; desel_cnt = 0; last_desel = 0;
      win_frames = 0; last_win_frames = 0; frames_total = 0; rdy_sel = 0; n_done = 0;
      viol_r2 = 0; viol_r3 = 0; viol_r4 = 0; viol_r5 = 0; viol_r6 = 0; viol_r8 = 0;
      last_rd = '0;
    end else begin
      rise_gap++;
      if (sel_n && ser_clk) viol_r2++;
      if (!sel_n && ser_clk && prev_sck && sd_out !== prev_sd) viol_r2++;
      if (!sel_n && req_ready) rdy_sel++;
      if (rd_done) begin n_done++; last_rd = rd_data; end
      if (rd_done && prev_done) viol_r5++;
      if (prev_sel && !sel_n) begin
        if (frames_total > 0 && desel_cnt < 2 * (int'(div_n) + 1)) viol_r8++;
        last_desel = desel_cnt;
        nbits = 0; win_frames = 0;
      end
      if (!prev_sel && sel_n) begin
        if (nbits != 0) viol_r6++;
        last_win_frames = win_frames;
        desel_cnt = 0;
      end
      if (sel_n) desel_cnt++;
      if (!sel_n && ser_clk && !prev_sck) begin
        if ((nbits > 0 || win_frames > 0) && rise_gap != 2 * (int'(div_n) + 1)) viol_r2++;
        rise_gap = 0;
        fr = {fr[14:0], sd_out};
        oe_rec[nbits] = sd_oe;
        nbits++;
        if (nbits == 7) begin
          cur_rd_s = fr[6];
          cur_byte = smem[fr[5:0]];
        end
        if (nbits == 16) begin
          last_frame = fr; frames_total++; win_frames++;
          if (fr[15]) begin
            for (int i = 0; i < 16; i++) if (oe_rec[i] != (i < 7)) viol_r4++;
          end else begin
            if (fr[8]) viol_r3++;
            if (oe_rec != 16'hFFFF) viol_r3++;
            smem[fr[14:9]] = fr[7:0];
          end
          nbits = 0;
        end
      end
      if (!sel_n && !ser_clk && prev_sck && cur_rd_s && nbits >= 8)
        sd_in = cur_byte[15 - nbits];
      prev_sck = ser_clk; prev_sel = sel_n; prev_sd = sd_out; prev_done = rd_done;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic push(input bit rd, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(sel_n && req_ready)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(sel_n === 1'b1 && ser_clk === 1'b0, "R10 select/clock after reset",
        {sel_n, ser_clk}, 2'b10);
    chk(sd_oe === 1'b0 && req_ready === 1'b1 && rd_done === 1'b0,
        "R10 oe/ready/done after reset", {sd_oe, req_ready, rd_done}, 3'b010);
  endtask

  task automatic t_single_write();
    int f0;
    div_n = 8'd1; f0 = frames_total; rdy_sel = 0;
    push(1'b0, 6'h15, 8'hA5);
    wait_idle();
    chk(frames_total == f0 + 1, "R1 one frame per write", frames_total - f0, 1);
    chk(last_frame == {1'b0, 6'h15, 1'b0, 8'hA5}, "R1 R3 write frame bits",
        last_frame, {1'b0, 6'h15, 1'b0, 8'hA5});
    chk(rdy_sel == 1, "R9 one ready cycle at write close", rdy_sel, 1);
  endtask

  task automatic t_single_read();
    int d0;
    div_n = 8'd0; d0 = n_done; rdy_sel = 0;
    push(1'b1, 6'h15, 8'hFF);
    wait_idle();
    chk(last_frame[15:9] == {1'b1, 6'h15}, "R1 read header bits",
        last_frame[15:9], {1'b1, 6'h15});
    chk(last_rd == 8'hA5, "R5 read byte", last_rd, 8'hA5);
    chk(n_done == d0 + 1, "R5 one done pulse", n_done - d0, 1);
    chk(rdy_sel == 0, "R9 no ready inside read frame", rdy_sel, 0);
  endtask

  task automatic t_burst_write();
    int f0;
    div_n = 8'd2; f0 = frames_total;
    push(1'b0, 6'h01, 8'h3C);
    push(1'b0, 6'h3F, 8'hC3);
    wait_idle();
    chk(last_win_frames == 2, "R7 two writes in one select window", last_win_frames, 2);
    chk(frames_total == f0 + 2, "R7 burst frame count", frames_total - f0, 2);
    push(1'b1, 6'h3F, 8'h00);
    wait_idle();
    chk(last_rd == 8'hC3, "R5 R7 second burst value", last_rd, 8'hC3);
    push(1'b1, 6'h01, 8'h00);
    wait_idle();
    chk(last_rd == 8'h3C, "R5 R7 first burst value", last_rd, 8'h3C);
  endtask

  task automatic t_write_then_read();
    div_n = 8'd1;
    push(1'b0, 6'h20, 8'h5A);
    push(1'b1, 6'h20, 8'h00);
    wait_idle();
    chk(last_win_frames == 1, "R11 read in its own window", last_win_frames, 1);
    chk(last_desel == 4, "R11 R8 gap before chained read", last_desel, 4);
    chk(last_rd == 8'h5A, "R11 read after write", last_rd, 8'h5A);
  endtask

  task automatic t_slow_reads();
    div_n = 8'd3;
    push(1'b1, 6'h09, 8'h00);
    push(1'b1, 6'h0A, 8'h00);
    wait_idle();
    chk(last_win_frames == 1, "R8 reads not chained", last_win_frames, 1);
    chk(last_rd == 8'h49, "R5 second slow read", last_rd, 8'h49);
    chk(last_frame[15:9] == {1'b1, 6'h0A}, "R1 slow read header",
        last_frame[15:9], {1'b1, 6'h0A});
  endtask

  task automatic t_line_rules();
    chk(viol_r2 == 0, "R2 clock period and bit stability", viol_r2, 0);
    chk(viol_r3 == 0, "R3 write gap and drive", viol_r3, 0);
    chk(viol_r4 == 0, "R4 read turnaround", viol_r4, 0);
    chk(viol_r5 == 0, "R5 done pulse width", viol_r5, 0);
    chk(viol_r6 == 0, "R6 no cut frames", viol_r6, 0);
    chk(viol_r8 == 0, "R8 minimum deselect", viol_r8, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_single_read();
    t_burst_write();
    t_write_then_read();
    t_slow_reads();
    t_line_rules();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule